// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a clocked one-shot. Three asynchronous control pins (an active-low trigger, an active-high trigger and an active-low clear) are brought into the clock domain. Each one is compared with its own value on the previous clock to detect edges. A qualifying edge starts a pulse on a true output and a complementary output. The pulse lasts for a number of clock cycles taken from a length input at the moment of the trigger. A cycle counter takes the place of an analog resistor-capacitor timer.

A fresh qualifying trigger during a pulse restarts the count from the latest trigger. Triggers repeated often enough therefore hold the output active indefinitely. Pulling clear low ends any pulse and keeps the block idle for as long as clear stays low. A second independent channel is made by instantiating the block again.

Top module: `oneshot_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `q` is 0 and `q_n` is 1.
- R2: With `trig_a_n` low, a 0-to-1 change of `trig_b` starts a pulse. `q` first reads 1 after the third rising clock edge that follows the input change.
- R3: With `trig_b` high, a 1-to-0 change of `trig_a_n` starts a pulse with the same latency as R2.
- R4: With `trig_a_n` low and `trig_b` high, a 0-to-1 change of `clear_n` starts a pulse with the same latency as R2.
- R5: A pulse holds `q` high for exactly N clock cycles. N is the value of `pulse_len` when the trigger is accepted. Later changes of `pulse_len` do not alter a running pulse.
- R6: A qualifying trigger during a pulse reloads the count with the current `pulse_len`. The pulse then ends N cycles after the latest trigger, with no low cycle in between.
- R7: Once `clear_n` goes low, `q` is 0 from the third rising clock edge after the change. `q` stays 0 while `clear_n` stays low.
- R8: While the synchronized clear is low, no trigger is accepted. This includes a trigger edge that arrives in the same cycle as the clear.
- R9: Edges that do not meet one of the gated conditions produce no pulse. These are a rising `trig_b` while `trig_a_n` is high, a falling `trig_b`, a rising `trig_a_n`, and a falling `trig_a_n` while `trig_b` is low.
- R10: A trigger accepted with `pulse_len` equal to 0 produces no pulse. Such a trigger also leaves a running pulse unchanged.
- R11: `q_n` is the inverse of `q` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_a_n | input | 1 | Active-low gated trigger, asynchronous |
| trig_b | input | 1 | Active-high gated trigger, asynchronous |
| clear_n | input | 1 | Active-low clear, asynchronous |
| pulse_len | input | LEN_W | Pulse length in clock cycles |
| q | output | 1 | Pulse output, high while active |
| q_n | output | 1 | Inverse of `q` |

## Verification
The assertions assume that `pulse_len` is steady around the clock edge at which a trigger is taken. They also assume that the three control pins hold their idle levels while reset is asserted, so that releasing reset does not look like an edge. The stimulus changes every pin only on falling clock edges. It changes `pulse_len` only where no trigger can be decoded, except in the cases that test R5 and R10, and there it keeps the value fixed across the cycle in which the trigger is taken. Each test leaves the block idle, with clear high, before the next one begins. Whenever `clear_n` is raised with `trig_a_n` low, `trig_b` has already been lowered, so no trigger is started by accident.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // synchronizer flops ahead of the edge-history flop
    localparam int SYNC_DEPTH = 2;

    // pin slots in the conditioned-pin vector
    localparam int PIN_A    = 0;
    localparam int PIN_B    = 1;
    localparam int PIN_CLR  = 2;
    localparam int NUM_PINS = 3;

    // level each pin rests at when idle; used as reset value of its chain
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b101;

    // a conditioned pin: level this cycle and level one cycle before
    typedef struct packed {
        logic now;
        logic prev;
    } pin_view_t;

    function automatic logic went_high(pin_view_t p);
        return p.now & ~p.prev;
    endfunction

    function automatic logic went_low(pin_view_t p);
        return ~p.now & p.prev;
    endfunction

    // the three gated start conditions
    function automatic logic start_hit(pin_view_t a_n, pin_view_t b, pin_view_t clr_n);
        logic by_b;
        logic by_a;
        logic by_clr;
        by_b   = ~a_n.now & went_high(b);
        by_a   = b.now & went_low(a_n);
        by_clr = ~a_n.now & b.now & went_high(clr_n);
        return by_b | by_a | by_clr;
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    output pin_view_t view
);

    localparam int CHAIN = SYNC_DEPTH + 1;

    logic [CHAIN-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {CHAIN{IDLE_LVL}};
        end else begin
            pipe <= {pipe[CHAIN-2:0], raw};
        end
    end

    assign view.now  = pipe[SYNC_DEPTH-1];
    assign view.prev = pipe[SYNC_DEPTH];

endmodule

// File: rtl/oneshot_trig_decode.sv
module oneshot_trig_decode
    import oneshot_pkg::*;
(
    input  pin_view_t a_view,
    input  pin_view_t b_view,
    input  pin_view_t clr_view,
    output logic      fire,
    output logic      clr_ok
);

    assign fire   = start_hit(a_view, b_view, clr_view);
    assign clr_ok = clr_view.now;

endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
    import oneshot_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             clr_ok,
    input  logic [LEN_W-1:0] len,
    output logic             q,
    output logic             q_n
);

    localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] ZERO = '0;

    typedef struct packed {
        logic             running;
        logic [LEN_W-1:0] remain;
    } timer_t;

    timer_t cur;
    timer_t nxt;
    logic   idle_r;

    always_comb begin
        nxt = cur;
        if (!clr_ok) begin
            nxt.running = 1'b0;
            nxt.remain  = ZERO;
        end else if (fire && (len != ZERO)) begin
            nxt.running = 1'b1;
            nxt.remain  = len;
        end else if (cur.running) begin
            if (cur.remain == ONE) begin
                nxt.running = 1'b0;
                nxt.remain  = ZERO;
            end else begin
                nxt.remain = cur.remain - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            idle_r <= 1'b1;
        end else begin
            cur    <= nxt;
            idle_r <= ~nxt.running;
        end
    end

    assign q   = cur.running;
    assign q_n = idle_r;

    AST_CLR_KILLS: assert property (@(posedge clk) disable iff (rst)
        !clr_ok |=> !q) else $error("clear did not end pulse"); // R7

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && fire && (len != ZERO)) |=> (q && (cur.remain == $past(len))))
        else $error("trigger did not load full length"); // R6

    AST_ZERO_LEN_INERT: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && fire && (len == ZERO) && !q) |=> !q)
        else $error("zero length trigger started a pulse"); // R10

    AST_LAST_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && !fire && q && (cur.remain == ONE)) |=> !q)
        else $error("pulse overran its length"); // R5

    AST_RUNNING_NONZERO: assert property (@(posedge clk) disable iff (rst)
        q |-> (cur.remain != ZERO)) else $error("running with empty count"); // R5

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        q_n != q) else $error("outputs not complementary"); // R11

endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen
    import oneshot_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_a_n,
    input  logic             trig_b,
    input  logic             clear_n,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             q,
    output logic             q_n
);

    logic [NUM_PINS-1:0] raw_pins;
    pin_view_t           views [NUM_PINS];
    logic                fire_w;
    logic                clr_ok_w;

    always_comb begin
        raw_pins          = '0;
        raw_pins[PIN_A]   = trig_a_n;
        raw_pins[PIN_B]   = trig_b;
        raw_pins[PIN_CLR] = clear_n;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        oneshot_sync #(
            .IDLE_LVL (PIN_IDLE[i])
        ) u_sync (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_pins[i]),
            .view (views[i])
        );
    end

    oneshot_trig_decode u_decode (
        .a_view   (views[PIN_A]),
        .b_view   (views[PIN_B]),
        .clr_view (views[PIN_CLR]),
        .fire     (fire_w),
        .clr_ok   (clr_ok_w)
    );

    oneshot_pulse_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire_w),
        .clr_ok (clr_ok_w),
        .len    (pulse_len),
        .q      (q),
        .q_n    (q_n)
    );

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(fire_w && clr_ok_w)) else $error("pulse without trigger"); // R2

    AST_NO_START_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!clr_ok_w && !q) |=> !q) else $error("pulse started during clear"); // R8

endmodule

// File: tb/oneshot_gen_test.sv
`timescale 1ns/1ps
module oneshot_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        a_n;
    logic        b;
    logic        clr_n;
    logic [15:0] len;
    logic        q;
    logic        q_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int base  = 0;
    bit done  = 1'b0;

    int    at_q  [$];
    bit    val_q [$];
    string tag_q [$];

    oneshot_gen #(.LEN_W(16)) uut (
        .clk       (clk),
        .rst       (rst),
        .trig_a_n  (a_n),
        .trig_b    (b),
        .clear_n   (clr_n),
        .pulse_len (len),
        .q         (q),
        .q_n       (q_n)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items due in the current cycle
    always @(negedge clk) begin
        if (!rst) begin
            while (at_q.size() > 0 && at_q[0] <= cyc) begin
                total++;
                if (at_q[0] != cyc || q !== val_q[0]) begin
                    bad++;
                    $display("FAIL %s: cycle %0d q=%b expected %b (due %0d)",
                             tag_q[0], cyc, q, val_q[0], at_q[0]);
                end
                total++;
                if (q_n !== ~val_q[0]) begin
                    bad++;
                    $display("FAIL R11: cycle %0d q_n=%b expected %b", cyc, q_n, ~val_q[0]);
                end
                void'(at_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    // driver helpers
    task automatic mark();
        @(negedge clk);
        base = cyc;
    endtask

    task automatic expect_span(int lo, int hi, bit v, string tag);
        for (int i = lo; i <= hi; i++) begin
            at_q.push_back(base + i);
            val_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic at(int off);
        while (cyc < base + off) @(negedge clk);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (at_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a_n = 1'b1; b = 1'b0; clr_n = 1'b1; len = 16'd0;
        settle(4);
        total++;
        if (q !== 1'b0 || q_n !== 1'b1) begin
            bad++;
            $display("FAIL R1: in reset q=%b q_n=%b expected 0/1", q, q_n);
        end
        rst = 1'b0;
        settle(1);
        total++;
        if (q !== 1'b0 || q_n !== 1'b1) begin
            bad++;
            $display("FAIL R1: after reset q=%b q_n=%b expected 0/1", q, q_n);
        end

        // R2 + R5: B rises with A low, length 5, length changed mid-pulse
        a_n = 1'b0;
        settle(4);
        mark();
        expect_span(1, 2, 1'b0, "R2");
        expect_span(3, 7, 1'b1, "R5");
        expect_span(8, 10, 1'b0, "R5");
        b = 1'b1; len = 16'd5;
        at(5); len = 16'd2;
        drain();
        b = 1'b0; a_n = 1'b1;
        settle(4);

        // R3: A falls with B high, length 3
        b = 1'b1;
        settle(4);
        mark();
        expect_span(1, 2, 1'b0, "R3");
        expect_span(3, 5, 1'b1, "R3");
        expect_span(6, 8, 1'b0, "R3");
        a_n = 1'b0; len = 16'd3;
        drain();
        b = 1'b0; a_n = 1'b1;
        settle(4);

        // R8: qualifying edges while clear is low start nothing
        mark();
        expect_span(1, 12, 1'b0, "R8");
        clr_n = 1'b0; len = 16'd4;
        at(4); a_n = 1'b0;
        at(6); b = 1'b1;
        drain();

        // R4: clear rises with A low and B high, length 4
        mark();
        expect_span(1, 2, 1'b0, "R4");
        expect_span(3, 6, 1'b1, "R4");
        expect_span(7, 9, 1'b0, "R4");
        clr_n = 1'b1;
        drain();
        b = 1'b0;
        settle(4);

        // R6: retriggers extend, latest length wins
        mark();
        expect_span(1, 2, 1'b0, "R6");
        expect_span(3, 14, 1'b1, "R6");
        expect_span(15, 18, 1'b0, "R6");
        b = 1'b1; len = 16'd6;
        at(2); b = 1'b0;
        at(4); b = 1'b1;
        at(7); b = 1'b0;
        at(9); b = 1'b1; len = 16'd3;
        drain();
        b = 1'b0;
        settle(4);

        // R7: clear cuts a long pulse; R8: trigger during clear ignored
        mark();
        expect_span(1, 2, 1'b0, "R7");
        expect_span(3, 8, 1'b1, "R7");
        expect_span(9, 13, 1'b0, "R7");
        expect_span(14, 24, 1'b0, "R8");
        b = 1'b1; len = 16'd20;
        at(6); clr_n = 1'b0;
        at(10); b = 1'b0;
        at(12); b = 1'b1;
        at(16); b = 1'b0;
        at(18); clr_n = 1'b1;
        drain();

        // R8: clear and trigger edge in the same cycle
        mark();
        expect_span(1, 12, 1'b0, "R8");
        clr_n = 1'b0; b = 1'b1; len = 16'd5;
        at(5); b = 1'b0;
        at(7); clr_n = 1'b1;
        drain();
        a_n = 1'b1;
        settle(4);

        // R9: non-qualifying edges
        mark();
        expect_span(1, 12, 1'b0, "R9");
        b = 1'b1;
        at(4); b = 1'b0;
        at(6); a_n = 1'b0;
        at(8); a_n = 1'b1;
        drain();
        a_n = 1'b0;
        settle(4);

        // R10: zero length starts nothing
        mark();
        expect_span(1, 8, 1'b0, "R10");
        b = 1'b1; len = 16'd0;
        at(4); b = 1'b0;
        drain();

        // R10: zero length retrigger leaves a running pulse as it is
        mark();
        expect_span(1, 2, 1'b0, "R10");
        expect_span(3, 10, 1'b1, "R10");
        expect_span(11, 13, 1'b0, "R10");
        b = 1'b1; len = 16'd8;
        at(3); b = 1'b0;
        at(5); b = 1'b1; len = 16'd0;
        at(12); len = 16'd8;
        drain();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule